// File: doc/BRIEF.md
# Saturating 56-bit Arithmetic/Logic Stage

This block is the result stage of a multiply-accumulate slice. It combines two 56-bit operands, X and Y, under a 6-bit operation code. The code space is sparse: six arithmetic operations and ten bitwise operations are legal. The stage registers a 56-bit result Z together with an overflow flag, two carry taps and a selected carry output. Static configuration inputs do four things. They can exchange the operands. They choose where the operation code comes from. They choose the carry-in source. They set how out-of-range arithmetic results are bounded.

The overflow range has a programmable most-significant bit position, called the rank. In signed mode the legal range is -2^rank to 2^rank-1. In unsigned mode it is 0 to 2^(rank+1)-1. An out-of-range arithmetic result always raises the overflow flag. With saturation enabled, Z is also clamped to the nearer bound. Otherwise Z keeps the wrapped low 56 bits. A write enable freezes every register. A separate synchronous clear acts on Z alone.

Top module: `sat_alu`

## Requirements
- R1: While rst_ni is low, z_o, ovf_o, co_o, co37_o and co49_o are all 0.
- R2: The arithmetic codes compute the following, with C the selected carry-in: 000000 gives Y+X, 000001 gives Y+X+C, 001010 gives Y-X, 001011 gives Y-X-C, 000101 gives Y+C and 000111 gives Y-C.
- R3: The bitwise codes compute the following: 100000 gives Y, 110000 gives ~Y, 100001 gives Y&X, 101001 gives Y&~X, 110001 gives ~(Y&X), 100010 gives Y|X, 101010 gives Y|~X, 110010 gives ~(Y|X), 100011 gives Y^X and 110011 gives ~(Y^X).
- R4: Every other code gives Z=0, with ovf_o, co37_o and co49_o all 0.
- R5: With cfg_swap_i=1, x_i takes the Y role and y_i takes the X role.
- R6: With cfg_dyn_op_i=1, the code is opd_bus_i[5:0] and cfg_op_i is ignored. With cfg_dyn_op_i=0, the code is cfg_op_i and opd_bus_i is ignored.
- R7: With cfg_cci_sel_i=1, the carry-in C is cci_i. With cfg_cci_sel_i=0, C is ci_i.
- R8: co37_o and co49_o are the carries out of bits 37 and 49 of the sum Y+B+K. For the codes in R2 order, B is X, X, ~X, ~X, 0 and all-ones, and K is 0, C, 1, ~C, C and ~C. Both taps are 0 for bitwise codes. co_o equals co49_o when cfg_co_hi_i=1 and co37_o otherwise.
- R9: The exact arithmetic result is formed with the operands sign-extended when cfg_signed_i=1 and zero-extended otherwise. ovf_o is 1 exactly when that result lies outside the rank range, where the rank is cfg_rank_i and values above 55 count as 55. Bitwise codes never set ovf_o.
- R10: With cfg_sat_en_i=1, an out-of-range result is clamped to the nearer bound. With cfg_sat_en_i=0, Z holds the low 56 bits of the exact result.
- R11: While we_i=0, all output registers hold their values.
- R12: rz_i=1 clears Z at the next edge, whatever the state of we_i. It leaves ovf_o and the carry outputs untouched.
- R13: All outputs are registered and appear one clock edge after their inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register update enable |
| rz_i | input | 1 | Synchronous clear of Z |
| x_i | input | 56 | X operand |
| y_i | input | 56 | Y operand |
| ci_i | input | 1 | Local carry-in |
| cci_i | input | 1 | Cascade carry-in |
| opd_bus_i | input | 18 | Data bus; the low 6 bits are the dynamic code |
| cfg_op_i | input | 6 | Static operation code |
| cfg_dyn_op_i | input | 1 | Take the code from opd_bus_i |
| cfg_swap_i | input | 1 | Exchange the operands |
| cfg_cci_sel_i | input | 1 | Take the carry-in from cci_i |
| cfg_signed_i | input | 1 | Signed range and extension |
| cfg_sat_en_i | input | 1 | Clamp out-of-range results |
| cfg_rank_i | input | 6 | MSB rank of the range |
| cfg_co_hi_i | input | 1 | co_o follows the bit 49 carry |
| z_o | output | 56 | Registered result |
| ovf_o | output | 1 | Out-of-range flag |
| co_o | output | 1 | Selected carry |
| co37_o | output | 1 | Carry out of bit 37 |
| co49_o | output | 1 | Carry out of bit 49 |

## Verification
The bench builds the block with its default parameters. These are a 56-bit datapath, carry taps at bits 37 and 49, an 18-bit data bus and a 6-bit rank capped at 55. That width lets the tests reach both carry taps with carry chains of just the right length. It also reaches the signed clamp at rank 32 in both directions and the full-width range at rank 55. A low rank such as 7 brings unsigned clamping at 255 and at zero within reach using small operands.

// File: rtl/sat_alu_pkg.sv
package sat_alu_pkg;
  localparam int unsigned OP_W = 6;
  typedef logic [OP_W-1:0] op_t;

  localparam op_t OP_ADD  = 6'b000000;
  localparam op_t OP_ADDC = 6'b000001;
  localparam op_t OP_SUB  = 6'b001010;
  localparam op_t OP_SUBC = 6'b001011;
  localparam op_t OP_INCY = 6'b000101;
  localparam op_t OP_DECY = 6'b000111;

  localparam op_t OP_PASS = 6'b100000;
  localparam op_t OP_NOTY = 6'b110000;
  localparam op_t OP_AND  = 6'b100001;
  localparam op_t OP_ANDN = 6'b101001;
  localparam op_t OP_NAND = 6'b110001;
  localparam op_t OP_OR   = 6'b100010;
  localparam op_t OP_ORN  = 6'b101010;
  localparam op_t OP_NOR  = 6'b110010;
  localparam op_t OP_XOR  = 6'b100011;
  localparam op_t OP_XNOR = 6'b110011;

  typedef enum logic [1:0] {LF_PASS = 2'd0, LF_AND = 2'd1, LF_OR = 2'd2, LF_XOR = 2'd3} lfn_e;

  typedef struct packed {
    logic legal;
    logic is_logic;
    logic use_x;    // X participates in the sum
    logic sub_x;    // X is subtracted
    logic cin_pos;  // +C
    logic cin_neg;  // -C
    logic inv_x;
    logic inv_out;
    lfn_e lfn;
  } dec_t;
endpackage

// File: rtl/sat_alu_decode.sv
module sat_alu_decode
  import sat_alu_pkg::*;
(
  input  op_t  op_i,
  output dec_t dec_o
);
  always_comb begin
    dec_o = '0;
    dec_o.lfn = LF_PASS;
    unique case (op_i)
      OP_ADD:  begin dec_o.legal = 1'b1; dec_o.use_x = 1'b1; end
      OP_ADDC: begin dec_o.legal = 1'b1; dec_o.use_x = 1'b1; dec_o.cin_pos = 1'b1; end
      OP_SUB:  begin dec_o.legal = 1'b1; dec_o.use_x = 1'b1; dec_o.sub_x = 1'b1; end
      OP_SUBC: begin dec_o.legal = 1'b1; dec_o.use_x = 1'b1; dec_o.sub_x = 1'b1; dec_o.cin_neg = 1'b1; end
      OP_INCY: begin dec_o.legal = 1'b1; dec_o.cin_pos = 1'b1; end
      OP_DECY: begin dec_o.legal = 1'b1; dec_o.cin_neg = 1'b1; end
      OP_PASS, OP_NOTY, OP_AND, OP_ANDN, OP_NAND,
      OP_OR, OP_ORN, OP_NOR, OP_XOR, OP_XNOR: begin
        dec_o.legal    = 1'b1;
        dec_o.is_logic = 1'b1;
        dec_o.inv_out  = op_i[4];
        dec_o.inv_x    = op_i[3];
        dec_o.lfn      = lfn_e'(op_i[1:0]);
      end
      default: dec_o = '0;
    endcase
  end
endmodule

// File: rtl/sat_alu_arith.sv
module sat_alu_arith
  import sat_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 56,
  parameter int unsigned TAP_LO = 37,
  parameter int unsigned TAP_HI = 49,
  localparam int unsigned EXT_W = DATA_W + 2
) (
  input  logic [DATA_W-1:0]       a_i,     // Y role
  input  logic [DATA_W-1:0]       b_i,     // X role
  input  logic                    c_i,
  input  logic                    signed_i,
  input  dec_t                    dec_i,
  output logic signed [EXT_W-1:0] exact_o,
  output logic [DATA_W-1:0]       logic_o,
  output logic                    cy_lo_o,
  output logic                    cy_hi_o
);
  logic signed [EXT_W-1:0] ea, eb, xterm, cpos, cneg;
  logic [DATA_W-1:0] bop, lx, lres;
  logic k;

  always_comb begin
    ea    = signed_i ? {{2{a_i[DATA_W-1]}}, a_i} : {2'b00, a_i};
    eb    = signed_i ? {{2{b_i[DATA_W-1]}}, b_i} : {2'b00, b_i};
    xterm = dec_i.use_x ? (dec_i.sub_x ? -eb : eb) : '0;
    cpos  = {{(EXT_W-1){1'b0}}, c_i & dec_i.cin_pos};
    cneg  = {{(EXT_W-1){1'b0}}, c_i & dec_i.cin_neg};
    exact_o = ea + xterm + cpos - cneg;
  end

  // Adder view for the carry taps
  always_comb begin
    if (dec_i.use_x) bop = dec_i.sub_x ? ~b_i : b_i;
    else             bop = dec_i.cin_neg ? '1 : '0;
    if (dec_i.cin_neg)                   k = ~c_i;
    else if (dec_i.use_x && dec_i.sub_x) k = 1'b1;
    else                                 k = c_i & dec_i.cin_pos;
  end

  logic [1:0] cy;
  for (genvar g = 0; g < 2; g++) begin : g_tap
    localparam int unsigned TP = (g == 0) ? TAP_LO : TAP_HI;
    logic [TP+1:0] psum;
    assign psum  = {1'b0, a_i[TP:0]} + {1'b0, bop[TP:0]} + {{(TP+1){1'b0}}, k};
    assign cy[g] = psum[TP+1];
  end
  assign cy_lo_o = cy[0];
  assign cy_hi_o = cy[1];

  always_comb begin
    lx = dec_i.inv_x ? ~b_i : b_i;
    unique case (dec_i.lfn)
      LF_AND:  lres = a_i & lx;
      LF_OR:   lres = a_i | lx;
      LF_XOR:  lres = a_i ^ lx;
      default: lres = a_i;
    endcase
    logic_o = dec_i.inv_out ? ~lres : lres;
  end
endmodule

// File: rtl/sat_alu_clamp.sv
module sat_alu_clamp #(
  parameter int unsigned DATA_W   = 56,
  parameter int unsigned RANK_W   = 6,
  parameter int unsigned MAX_RANK = 55,
  localparam int unsigned EXT_W   = DATA_W + 2
) (
  input  logic signed [EXT_W-1:0] exact_i,
  input  logic [RANK_W-1:0]       rank_i,
  input  logic                    signed_i,
  input  logic                    sat_en_i,
  output logic [DATA_W-1:0]       z_o,
  output logic                    oor_o
);
  localparam logic signed [EXT_W-1:0] ONE = EXT_W'(1);

  logic [RANK_W-1:0] rank_eff;
  logic [RANK_W:0]   shamt;
  logic signed [EXT_W-1:0] hi, lo;
  logic above, below;

  always_comb begin
    rank_eff = (rank_i > RANK_W'(MAX_RANK)) ? RANK_W'(MAX_RANK) : rank_i;
    shamt    = {1'b0, rank_eff} + {{RANK_W{1'b0}}, ~signed_i};
    hi       = (ONE <<< shamt) - ONE;
    lo       = signed_i ? -(ONE <<< rank_eff) : '0;
    above    = exact_i > hi;
    below    = exact_i < lo;
    oor_o    = above | below;
    if (sat_en_i && above)      z_o = hi[DATA_W-1:0];
    else if (sat_en_i && below) z_o = lo[DATA_W-1:0];
    else                        z_o = exact_i[DATA_W-1:0];
  end
endmodule

// File: rtl/sat_alu.sv
module sat_alu
  import sat_alu_pkg::*;
#(
  parameter int unsigned DATA_W   = 56,
  parameter int unsigned TAP_LO   = 37,
  parameter int unsigned TAP_HI   = 49,
  parameter int unsigned OPBUS_W  = 18,
  parameter int unsigned RANK_W   = 6,
  parameter int unsigned MAX_RANK = 55,
  localparam int unsigned EXT_W   = DATA_W + 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic               rz_i,
  input  logic [DATA_W-1:0]  x_i,
  input  logic [DATA_W-1:0]  y_i,
  input  logic               ci_i,
  input  logic               cci_i,
  input  logic [OPBUS_W-1:0] opd_bus_i,
  input  logic [OP_W-1:0]    cfg_op_i,
  input  logic               cfg_dyn_op_i,
  input  logic               cfg_swap_i,
  input  logic               cfg_cci_sel_i,
  input  logic               cfg_signed_i,
  input  logic               cfg_sat_en_i,
  input  logic [RANK_W-1:0]  cfg_rank_i,
  input  logic               cfg_co_hi_i,
  output logic [DATA_W-1:0]  z_o,
  output logic               ovf_o,
  output logic               co_o,
  output logic               co37_o,
  output logic               co49_o
);
  op_t  op;
  dec_t dec;
  logic [DATA_W-1:0] opa, opb, logic_res, clamp_z, z_d;
  logic signed [EXT_W-1:0] exact;
  logic cin, cy_lo, cy_hi, oor, arith_ok;

  assign op  = cfg_dyn_op_i ? opd_bus_i[OP_W-1:0] : cfg_op_i;
  assign opa = cfg_swap_i ? x_i : y_i;
  assign opb = cfg_swap_i ? y_i : x_i;
  assign cin = cfg_cci_sel_i ? cci_i : ci_i;

  sat_alu_decode u_dec (.op_i(op), .dec_o(dec));

  sat_alu_arith #(.DATA_W(DATA_W), .TAP_LO(TAP_LO), .TAP_HI(TAP_HI)) u_arith (
    .a_i(opa), .b_i(opb), .c_i(cin), .signed_i(cfg_signed_i), .dec_i(dec),
    .exact_o(exact), .logic_o(logic_res), .cy_lo_o(cy_lo), .cy_hi_o(cy_hi)
  );

  sat_alu_clamp #(.DATA_W(DATA_W), .RANK_W(RANK_W), .MAX_RANK(MAX_RANK)) u_clamp (
    .exact_i(exact), .rank_i(cfg_rank_i), .signed_i(cfg_signed_i),
    .sat_en_i(cfg_sat_en_i), .z_o(clamp_z), .oor_o(oor)
  );

  assign arith_ok = dec.legal & ~dec.is_logic;

  always_comb begin
    if (!dec.legal)       z_d = '0;
    else if (dec.is_logic) z_d = logic_res;
    else                   z_d = clamp_z;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    z_o <= '0;
    else if (rz_i)  z_o <= '0;
    else if (we_i)  z_o <= z_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_o  <= 1'b0;
      co37_o <= 1'b0;
      co49_o <= 1'b0;
      co_o   <= 1'b0;
    end else if (we_i) begin
      ovf_o  <= arith_ok & oor;
      co37_o <= arith_ok & cy_lo;
      co49_o <= arith_ok & cy_hi;
      co_o   <= arith_ok & (cfg_co_hi_i ? cy_hi : cy_lo);
    end
  end

  AST_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i && !rz_i) |=> ($stable(z_o) && $stable(ovf_o) && $stable(co_o))); // R11
  AST_RZ_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rz_i |=> (z_o == '0)); // R12
  AST_RZ_KEEPS_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rz_i && !we_i) |=> ($stable(ovf_o) && $stable(co37_o) && $stable(co49_o))); // R12
  AST_ILLEGAL_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !dec.legal) |=> (z_o == '0 && !ovf_o && !co37_o && !co49_o)); // R4
  AST_CO_SELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (co_o == ($past(cfg_co_hi_i) ? co49_o : co37_o))); // R8
  AST_LOGIC_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && dec.legal && dec.is_logic) |=> !ovf_o); // R9
endmodule

// File: tb/sat_alu_bench.sv
module sat_alu_bench;
  localparam int CLK_PERIOD = 10;

  logic clk_i = 1'b0, rst_ni = 1'b0, we_i = 1'b1, rz_i = 1'b0;
  logic [55:0] x_i = '0, y_i = '0;
  logic ci_i = 1'b0, cci_i = 1'b0;
  logic [17:0] opd_bus_i = '0;
  logic [5:0] cfg_op_i = '0;
  logic cfg_dyn_op_i = 1'b0, cfg_swap_i = 1'b0, cfg_cci_sel_i = 1'b0;
  logic cfg_signed_i = 1'b1, cfg_sat_en_i = 1'b0, cfg_co_hi_i = 1'b0;
  logic [5:0] cfg_rank_i = 6'd55;
  logic [55:0] z_o;
  logic ovf_o, co_o, co37_o, co49_o;

  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  sat_alu u_sat_alu (.*);

  task automatic chk(input string tag, input string what, input logic [55:0] act, input logic [55:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic model(output logic [55:0] ez, output logic eo, output logic e37, output logic e49);
    logic [5:0] op; logic [55:0] a, b, bop; logic c, k, arith;
    logic signed [63:0] ea, eb, t, hi, lo; logic [63:0] s37, s49; int r;
    op = cfg_dyn_op_i ? opd_bus_i[5:0] : cfg_op_i;
    a = cfg_swap_i ? x_i : y_i;
    b = cfg_swap_i ? y_i : x_i;
    c = cfg_cci_sel_i ? cci_i : ci_i;
    ea = cfg_signed_i ? {{8{a[55]}}, a} : {8'b0, a};
    eb = cfg_signed_i ? {{8{b[55]}}, b} : {8'b0, b};
    arith = 1'b1; ez = '0; eo = 1'b0; e37 = 1'b0; e49 = 1'b0; bop = '0; k = 1'b0; t = '0;
    case (op)
      6'b000000: begin t = ea + eb;               bop = b;  k = 1'b0; end
      6'b000001: begin t = ea + eb + {63'b0, c};  bop = b;  k = c;    end
      6'b001010: begin t = ea - eb;               bop = ~b; k = 1'b1; end
      6'b001011: begin t = ea - eb - {63'b0, c};  bop = ~b; k = ~c;   end
      6'b000101: begin t = ea + {63'b0, c};       bop = '0; k = c;    end
      6'b000111: begin t = ea - {63'b0, c};       bop = '1; k = ~c;   end
      default: arith = 1'b0;
    endcase
    if (arith) begin
      r  = (cfg_rank_i > 6'd55) ? 55 : int'(cfg_rank_i);
      hi = cfg_signed_i ? (64'sd1 <<< r) - 64'sd1 : (64'sd1 <<< (r + 1)) - 64'sd1;
      lo = cfg_signed_i ? -(64'sd1 <<< r) : 64'sd0;
      eo = (t > hi) || (t < lo);
      if (cfg_sat_en_i && t > hi)      ez = hi[55:0];
      else if (cfg_sat_en_i && t < lo) ez = lo[55:0];
      else                             ez = t[55:0];
      s37 = {26'b0, a[37:0]} + {26'b0, bop[37:0]} + {63'b0, k};
      s49 = {14'b0, a[49:0]} + {14'b0, bop[49:0]} + {63'b0, k};
      e37 = s37[38];
      e49 = s49[50];
    end else begin
      case (op)
        6'b100000: ez = a;
        6'b110000: ez = ~a;
        6'b100001: ez = a & b;
        6'b101001: ez = a & ~b;
        6'b110001: ez = ~(a & b);
        6'b100010: ez = a | b;
        6'b101010: ez = a | ~b;
        6'b110010: ez = ~(a | b);
        6'b100011: ez = a ^ b;
        6'b110011: ez = ~(a ^ b);
        default:   ez = '0;
      endcase
    end
  endtask

  // Model inputs before the edge, sample one edge later (R13)
  task automatic step_check(input string tag);
    logic [55:0] ez; logic eo, e37, e49;
    model(ez, eo, e37, e49);
    @(posedge clk_i); #1;
    chk(tag, "z", z_o, ez);
    chk(tag, "ovf", {55'b0, ovf_o}, {55'b0, eo});
    chk(tag, "co37", {55'b0, co37_o}, {55'b0, e37});
    chk(tag, "co49", {55'b0, co49_o}, {55'b0, e49});
    chk(tag, "co", {55'b0, co_o}, {55'b0, cfg_co_hi_i ? e49 : e37});
  endtask

  task automatic t_reset();
    #1;
    chk("R1", "z", z_o, '0);
    chk("R1", "flags", {52'b0, ovf_o, co_o, co37_o, co49_o}, '0);
    @(negedge clk_i); rst_ni = 1'b1;
  endtask

  task automatic t_arith();
    logic [5:0] ops [6] = '{6'b000000, 6'b000001, 6'b001010, 6'b001011, 6'b000101, 6'b000111};
    foreach (ops[i]) begin
      for (int c = 0; c < 2; c++) begin
        @(negedge clk_i);
        cfg_op_i = ops[i]; ci_i = c[0];
        y_i = 56'h00_1234_5678_9ABC; x_i = 56'h00_0000_1111_2222;
        step_check("R2 arith");
      end
    end
    @(negedge clk_i);
    cfg_op_i = 6'b001010; y_i = 56'd10; x_i = 56'd3;
    @(posedge clk_i); #1;
    chk("R2 sub literal", "z", z_o, 56'd7);
  endtask

  task automatic t_logic();
    logic [5:0] ops [10] = '{6'b100000, 6'b110000, 6'b100001, 6'b101001, 6'b110001,
                             6'b100010, 6'b101010, 6'b110010, 6'b100011, 6'b110011};
    foreach (ops[i]) begin
      @(negedge clk_i);
      cfg_op_i = ops[i]; y_i = 56'hF0F0_AAAA_5555_CC; x_i = 56'hFF00_F0F0_0FF0_3C;
      step_check("R3 logic");
    end
    @(negedge clk_i);
    cfg_op_i = 6'b100011; y_i = 56'hFF; x_i = 56'h0F;
    @(posedge clk_i); #1;
    chk("R3 xor literal", "z", z_o, 56'hF0);
  endtask

  task automatic t_illegal();
    logic [5:0] ops [4] = '{6'b000010, 6'b111111, 6'b010000, 6'b001000};
    foreach (ops[i]) begin
      @(negedge clk_i);
      cfg_op_i = ops[i]; y_i = '1; x_i = 56'd1; ci_i = 1'b1;
      @(posedge clk_i); #1;
      chk("R4 illegal", "z", z_o, '0);
      chk("R4 illegal", "flags", {53'b0, ovf_o, co37_o, co49_o}, '0);
    end
  endtask

  task automatic t_swap();
    @(negedge clk_i);
    cfg_op_i = 6'b001010; cfg_swap_i = 1'b1; y_i = 56'd5; x_i = 56'd20;
    @(posedge clk_i); #1;
    chk("R5 swap", "z", z_o, 56'd15);
    @(negedge clk_i);
    cfg_op_i = 6'b101001; y_i = 56'hFF; x_i = 56'h0F;
    step_check("R5 swap andn");
    @(negedge clk_i); cfg_swap_i = 1'b0;
  endtask

  task automatic t_dyn_op();
    @(negedge clk_i);
    cfg_dyn_op_i = 1'b1; cfg_op_i = 6'b001010; opd_bus_i = 18'h3FFC0;
    y_i = 56'd100; x_i = 56'd23;
    @(posedge clk_i); #1;
    chk("R6 dynamic code", "z", z_o, 56'd123);
    @(negedge clk_i);
    cfg_dyn_op_i = 1'b0; opd_bus_i = 18'h0003F;
    @(posedge clk_i); #1;
    chk("R6 static code", "z", z_o, 56'd77);
  endtask

  task automatic t_carry_src();
    @(negedge clk_i);
    cfg_op_i = 6'b000001; y_i = 56'd50; x_i = 56'd8; ci_i = 1'b0; cci_i = 1'b1; cfg_cci_sel_i = 1'b1;
    @(posedge clk_i); #1;
    chk("R7 cascade carry", "z", z_o, 56'd59);
    @(negedge clk_i);
    cfg_cci_sel_i = 1'b0;
    @(posedge clk_i); #1;
    chk("R7 local carry", "z", z_o, 56'd58);
  endtask

  task automatic t_carry_taps();
    @(negedge clk_i);
    cfg_op_i = 6'b000000; y_i = 56'h00_003F_FFFF_FFFF; x_i = 56'd1; cfg_co_hi_i = 1'b0;
    @(posedge clk_i); #1;
    chk("R8 tap37", "co37/co49/co", {53'b0, co37_o, co49_o, co_o}, 56'b101);
    @(negedge clk_i);
    cfg_co_hi_i = 1'b1;
    @(posedge clk_i); #1;
    chk("R8 select hi", "co", {55'b0, co_o}, 56'd0);
    @(negedge clk_i);
    y_i = 56'h03_FFFF_FFFF_FFFF;
    @(posedge clk_i); #1;
    chk("R8 tap49", "co37/co49/co", {53'b0, co37_o, co49_o, co_o}, 56'b111);
    @(negedge clk_i);
    cfg_op_i = 6'b000111; ci_i = 1'b1; y_i = 56'd0;
    step_check("R8 decy borrow");
    @(negedge clk_i); cfg_co_hi_i = 1'b0; ci_i = 1'b0;
  endtask

  task automatic t_sat_signed();
    @(negedge clk_i);
    cfg_signed_i = 1'b1; cfg_sat_en_i = 1'b1; cfg_rank_i = 6'd32;
    cfg_op_i = 6'b000000; y_i = 56'h00_0000_FFFF_FFFF; x_i = 56'd5;
    @(posedge clk_i); #1;
    chk("R10 signed clamp hi", "z", z_o, 56'h00_0000_FFFF_FFFF);
    chk("R9 signed over", "ovf", {55'b0, ovf_o}, 56'd1);
    @(negedge clk_i);
    cfg_op_i = 6'b001010; y_i = 56'hFF_FFFF_0000_0000; x_i = 56'd1;
    @(posedge clk_i); #1;
    chk("R10 signed clamp lo", "z", z_o, 56'hFF_FFFF_0000_0000);
    chk("R9 signed under", "ovf", {55'b0, ovf_o}, 56'd1);
    @(negedge clk_i);
    cfg_op_i = 6'b000000; y_i = 56'h00_0000_7FFF_0000; x_i = 56'd1;
    step_check("R9 in range");
    @(negedge clk_i);
    cfg_rank_i = 6'd63; y_i = 56'h7F_FFFF_FFFF_FFFF; x_i = 56'd1;
    @(posedge clk_i); #1;
    chk("R9 rank capped", "z", z_o, 56'h7F_FFFF_FFFF_FFFF);
    chk("R9 rank capped", "ovf", {55'b0, ovf_o}, 56'd1);
  endtask

  task automatic t_sat_unsigned();
    @(negedge clk_i);
    cfg_signed_i = 1'b0; cfg_sat_en_i = 1'b1; cfg_rank_i = 6'd7;
    cfg_op_i = 6'b000000; y_i = 56'd200; x_i = 56'd100;
    @(posedge clk_i); #1;
    chk("R10 unsigned clamp hi", "z", z_o, 56'd255);
    @(negedge clk_i);
    cfg_op_i = 6'b001010; y_i = 56'd3; x_i = 56'd5;
    @(posedge clk_i); #1;
    chk("R10 unsigned clamp lo", "z", z_o, 56'd0);
    chk("R9 unsigned under", "ovf", {55'b0, ovf_o}, 56'd1);
    @(negedge clk_i);
    cfg_op_i = 6'b100010; y_i = '1; x_i = 56'd0;
    @(posedge clk_i); #1;
    chk("R9 logic no ovf", "ovf", {55'b0, ovf_o}, 56'd0);
  endtask

  task automatic t_nosat();
    @(negedge clk_i);
    cfg_signed_i = 1'b1; cfg_sat_en_i = 1'b0; cfg_rank_i = 6'd32;
    cfg_op_i = 6'b000000; y_i = 56'h00_0000_FFFF_FFFF; x_i = 56'd5;
    @(posedge clk_i); #1;
    chk("R10 wrap", "z", z_o, 56'h00_0001_0000_0004);
    chk("R9 flag without clamp", "ovf", {55'b0, ovf_o}, 56'd1);
    @(negedge clk_i); cfg_rank_i = 6'd55;
  endtask

  task automatic t_freeze_rz();
    @(negedge clk_i);
    cfg_op_i = 6'b000000; y_i = 56'd40; x_i = 56'd2; cfg_rank_i = 6'd3; cfg_signed_i = 1'b0;
    @(posedge clk_i); #1;
    chk("R9 setup", "ovf", {55'b0, ovf_o}, 56'd1);
    @(negedge clk_i);
    we_i = 1'b0; y_i = 56'd1; x_i = 56'd1;
    @(posedge clk_i); #1;
    chk("R11 freeze", "z", z_o, 56'd42);
    chk("R11 freeze", "ovf", {55'b0, ovf_o}, 56'd1);
    @(negedge clk_i);
    rz_i = 1'b1;
    @(posedge clk_i); #1;
    chk("R12 clear while frozen", "z", z_o, 56'd0);
    chk("R12 flags kept", "ovf", {55'b0, ovf_o}, 56'd1);
    @(negedge clk_i);
    we_i = 1'b1; rz_i = 1'b1; y_i = 56'd1; x_i = 56'd1;
    @(posedge clk_i); #1;
    chk("R12 clear beats we", "z", z_o, 56'd0);
    chk("R12 flags update", "ovf", {55'b0, ovf_o}, 56'd0);
    @(negedge clk_i); rz_i = 1'b0; cfg_rank_i = 6'd55; cfg_signed_i = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL R13 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_arith();
    t_logic();
    t_illegal();
    t_swap();
    t_dyn_op();
    t_carry_src();
    t_carry_taps();
    t_sat_signed();
    t_sat_unsigned();
    t_nosat();
    t_freeze_rz();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule